// File: doc/BRIEF.md
# BPSK Command Stream Decoder

This block turns a squared-up, single-bit phase-shift-keyed command line into bytes that a processor can read. The line carries a fixed-frequency carrier, nominally 16 kHz, and data rides on it as 180-degree phase reversals. A much faster system clock samples the line, at least 64 samples per carrier cycle. The block measures the time between line transitions with a counter. It decides when it has locked to the carrier. It then recognises a reversal as a half-cycle that is stretched well beyond its nominal length.

The decoding is differential. Each bit occupies a fixed number of carrier cycles, counted from the moment lock is gained. A bit window that holds a reversal decodes as 1, and a window without one decodes as 0. Bits are packed most significant first. Every completed byte goes into a small FIFO that the processor drains one byte at a time. The block drops lock when the carrier disappears and reports this on a loss flag. A byte that arrives while the FIFO is full is discarded, and a sticky overflow flag records the event until the processor clears it.

Top module: `bpsk_cmd_decoder`

## Requirements
- R1: While reset is asserted and directly after it, fifoEmpty is 1 and fifoFull, carrierLock, carrierLoss and overflow are 0.
- R2: carrierLock rises after LOCK_EDGES (default 16) consecutive line transitions whose spacing from the previous transition lies between HALF_CLKS - HALF_CLKS/4 and HALF_CLKS + HALF_CLKS/4 clocks inclusive. A spacing outside that window restarts the count. While locked, a spacing outside the window does not drop lock.
- R3: While locked, a transition spacing greater than 1.5 * HALF_CLKS counts as two half-cycles and marks a phase reversal, and any other spacing counts as one half-cycle. Each group of 2 * BIT_CYCLES half-cycles counted from the lock transition yields one bit: 1 if the group held a reversal, otherwise 0.
- R4: If carrierLock is 1 and no transition occurs for 2 * LOSS_PERIODS * HALF_CLKS clocks, carrierLock falls and carrierLoss becomes 1. carrierLoss stays 1 until lock is gained again. Bits of an unfinished byte are discarded both when lock is lost and when it is gained.
- R5: The first decoded bit after lock becomes bit 7 of the first byte. Every eighth bit completes a byte, which is written into the FIFO.
- R6: The FIFO holds FIFO_DEPTH bytes in arrival order. rdData shows the oldest byte whenever fifoEmpty is 0. rdEn removes that byte on the next clock edge. fifoFull is 1 exactly when FIFO_DEPTH bytes are held.
- R7: A byte completed while fifoFull is 1 is discarded, leaving the FIFO contents unchanged, and overflow is set. overflow stays 1 until ovfClr is asserted. A new overflow in the same cycle as ovfClr keeps it at 1.
- R8: rdEn while fifoEmpty is 1 has no effect: the FIFO stays empty and later bytes arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst | input | 1 | Synchronous active-high reset |
| rxLine | input | 1 | Squared-up phase-keyed command line, asynchronous |
| rdEn | input | 1 | Removes the oldest byte from the FIFO |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| rdData | output | 8 | Oldest byte in the FIFO |
| fifoEmpty | output | 1 | FIFO holds no byte |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH bytes |
| carrierLock | output | 1 | Carrier is locked and bits are being decoded |
| carrierLoss | output | 1 | Lock was dropped because transitions stopped |
| overflow | output | 1 | A byte was discarded because the FIFO was full |

## Verification
A wrong transition-spacing count or qualification counter shows up first on carrierLock. The flag rises one or more transitions early or late, which is within a few half-periods of the mistake. A half-cycle miscount or a missed reversal stays hidden until the next bit window closes. It then appears as a wrong bit in the byte that reaches rdData, up to eight bit windows later. A faulty silence timer moves the carrierLoss edge, and a faulty FIFO pointer or count shows on the very next push or pop through fifoEmpty, fifoFull or rdData. The bench therefore compares all outputs against a behavioural model on every clock, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/bpsk_dec_pkg.sv
package bpsk_dec_pkg;

  // Strobes from the timing control to the byte datapath, one cycle wide.
  typedef struct packed {
    logic bitValid;   // a bit window closed
    logic bitVal;     // decoded value of that window
    logic clearAsm;   // discard the partially assembled byte
  } bitStrobe_t;

  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_TRACK  = 1'b1
  } trackMode_t;

endpackage

// File: rtl/bpsk_edge_ctrl.sv
module bpsk_edge_ctrl
  import bpsk_dec_pkg::*;
#(
  parameter int HALF_CLKS    = 1562,
  parameter int BIT_CYCLES   = 8,
  parameter int LOCK_EDGES   = 16,
  parameter int LOSS_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  output bitStrobe_t strobe,
  output logic       locked,
  output logic       carrierLoss
);

  localparam int LOSS_LIM = 2 * LOSS_PERIODS * HALF_CLKS;
  localparam int CNT_W    = $clog2(LOSS_LIM + 2);
  localparam int TOL      = HALF_CLKS / 4;
  localparam int REV_MIN  = (3 * HALF_CLKS) / 2;
  localparam int SLOTS    = 2 * BIT_CYCLES;
  localparam int SLOT_W   = $clog2(SLOTS + 2);
  localparam int QUAL_W   = $clog2(LOCK_EDGES + 1);

  localparam logic [CNT_W-1:0]  WIN_LO_C  = CNT_W'(HALF_CLKS - TOL);
  localparam logic [CNT_W-1:0]  WIN_HI_C  = CNT_W'(HALF_CLKS + TOL);
  localparam logic [CNT_W-1:0]  REV_MIN_C = CNT_W'(REV_MIN);
  localparam logic [CNT_W-1:0]  LOSS_C    = CNT_W'(LOSS_LIM);
  localparam logic [SLOT_W-1:0] SLOTS_C   = SLOT_W'(SLOTS);
  localparam logic [QUAL_W-1:0] QUAL_TOP  = QUAL_W'(LOCK_EDGES - 1);

  // Two-flop synchroniser plus one history flop for edge detection.
  logic [2:0] syncQ;
  logic       edgeDet;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[1:0], rxLine};
  end

  assign edgeDet = syncQ[1] ^ syncQ[2];

  // Clocks since the last transition, saturating.
  logic [CNT_W-1:0] intervalCnt;

  always_ff @(posedge clk) begin
    if (rst)                  intervalCnt <= '0;
    else if (edgeDet)         intervalCnt <= CNT_W'(1);
    else if (~&intervalCnt)   intervalCnt <= intervalCnt + CNT_W'(1);
  end

  logic inWindow, isRev, silent;
  assign inWindow = (intervalCnt >= WIN_LO_C) && (intervalCnt <= WIN_HI_C);
  assign isRev    = intervalCnt > REV_MIN_C;
  assign silent   = intervalCnt >= LOSS_C;

  trackMode_t        mode;
  logic [QUAL_W-1:0] qualCnt;
  logic [SLOT_W-1:0] slotCnt, slotNext;
  logic              revSeen;
  bitStrobe_t        strobeQ;

  assign slotNext = slotCnt + (isRev ? SLOT_W'(2) : SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= MODE_SEARCH;
      carrierLoss <= 1'b0;
      qualCnt     <= '0;
      slotCnt     <= '0;
      revSeen     <= 1'b0;
      strobeQ     <= '0;
    end else begin
      strobeQ <= '0;
      if (mode == MODE_SEARCH) begin
        if (edgeDet) begin
          if (inWindow) begin
            if (qualCnt == QUAL_TOP) begin
              mode             <= MODE_TRACK;
              carrierLoss      <= 1'b0;
              qualCnt          <= '0;
              slotCnt          <= '0;
              revSeen          <= 1'b0;
              strobeQ.clearAsm <= 1'b1;
            end else begin
              qualCnt <= qualCnt + QUAL_W'(1);
            end
          end else begin
            qualCnt <= '0;
          end
        end
      end else if (edgeDet) begin
        if (slotNext >= SLOTS_C) begin
          strobeQ.bitValid <= 1'b1;
          strobeQ.bitVal   <= revSeen | isRev;
          slotCnt          <= '0;
          revSeen          <= 1'b0;
        end else begin
          slotCnt <= slotNext;
          revSeen <= revSeen | isRev;
        end
      end else if (silent) begin
        mode             <= MODE_SEARCH;
        carrierLoss      <= 1'b1;
        strobeQ.clearAsm <= 1'b1;
      end
    end
  end

  assign strobe = strobeQ;
  assign locked = (mode == MODE_TRACK);

  // Lock can only be gained on a qualified transition.
  assert_lock_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(edgeDet));

  // Loss of carrier follows a full silence window.
  assert_loss_after_silence_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(carrierLoss) |-> $past(intervalCnt) >= LOSS_C);

  assert_loss_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
    carrierLoss |-> !locked);

  // A bit is only emitted for a transition seen while tracking.
  assert_bit_from_edge_R3: assert property (@(posedge clk) disable iff (rst)
    strobeQ.bitValid |-> ($past(edgeDet) && $past(locked)));

endmodule

// File: rtl/bpsk_cmd_fifo.sv
module bpsk_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic             dropped
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doWrite, doRead;

  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);
  assign doWrite = wrEn && !full;
  assign doRead  = rdEn && !empty;
  assign dropped = wrEn && full;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + AW'(1);
      if (doRead)  rdPtr <= (rdPtr == LAST_C) ? '0 : rdPtr + AW'(1);
      unique case ({doWrite, doRead})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // A read on an empty FIFO with no write leaves it empty.
  assert_empty_read_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && rdEn && !wrEn) |=> empty);

  // A dropped write with no read keeps the FIFO full.
  assert_drop_keeps_full_R7: assert property (@(posedge clk) disable iff (rst)
    (dropped && !rdEn) |=> full);

endmodule

// File: rtl/bpsk_byte_path.sv
module bpsk_byte_path
  import bpsk_dec_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  bitStrobe_t strobe,
  input  logic       rdEn,
  input  logic       ovfClr,
  output logic [7:0] rdData,
  output logic       empty,
  output logic       full,
  output logic       overflow
);

  logic [6:0] shiftQ;
  logic [2:0] bitCnt;
  logic       pushReq, dropped;
  logic [7:0] pushByte;

  assign pushReq  = strobe.bitValid && !strobe.clearAsm && (bitCnt == 3'd7);
  assign pushByte = {shiftQ, strobe.bitVal};

  always_ff @(posedge clk) begin
    if (rst || strobe.clearAsm) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else if (strobe.bitValid) begin
      shiftQ <= {shiftQ[5:0], strobe.bitVal};
      bitCnt <= bitCnt + 3'd1;
    end
  end

  bpsk_cmd_fifo #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (8)
  ) fifo_i (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (pushReq),
    .wrData  (pushByte),
    .rdEn    (rdEn),
    .rdData  (rdData),
    .empty   (empty),
    .full    (full),
    .dropped (dropped)
  );

  always_ff @(posedge clk) begin
    if (rst)          overflow <= 1'b0;
    else if (dropped) overflow <= 1'b1;
    else if (ovfClr)  overflow <= 1'b0;
  end

  assert_ovf_from_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(full));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovfClr) |=> overflow);

  // Bytes are completed only on a bit strobe.
  assert_push_on_bit_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(empty) |-> $past(strobe.bitValid));

endmodule

// File: rtl/bpsk_cmd_decoder.sv
module bpsk_cmd_decoder
  import bpsk_dec_pkg::*;
#(
  parameter int HALF_CLKS    = 1562,
  parameter int BIT_CYCLES   = 8,
  parameter int LOCK_EDGES   = 16,
  parameter int LOSS_PERIODS = 4,
  parameter int FIFO_DEPTH   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  input  logic       rdEn,
  input  logic       ovfClr,
  output logic [7:0] rdData,
  output logic       fifoEmpty,
  output logic       fifoFull,
  output logic       carrierLock,
  output logic       carrierLoss,
  output logic       overflow
);

  bitStrobe_t strobe;

  bpsk_edge_ctrl #(
    .HALF_CLKS    (HALF_CLKS),
    .BIT_CYCLES   (BIT_CYCLES),
    .LOCK_EDGES   (LOCK_EDGES),
    .LOSS_PERIODS (LOSS_PERIODS)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .rxLine      (rxLine),
    .strobe      (strobe),
    .locked      (carrierLock),
    .carrierLoss (carrierLoss)
  );

  bpsk_byte_path #(
    .FIFO_DEPTH (FIFO_DEPTH)
  ) path_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rdEn     (rdEn),
    .ovfClr   (ovfClr),
    .rdData   (rdData),
    .empty    (fifoEmpty),
    .full     (fifoFull),
    .overflow (overflow)
  );

endmodule

// File: tb/bpsk_cmd_decoder_tb_top.sv
module bpsk_cmd_decoder_tb_top;

  localparam int H     = 32;
  localparam int BITC  = 8;
  localparam int LEDG  = 16;
  localparam int LPER  = 4;
  localparam int DEPTH = 4;
  localparam int LOSS  = 2 * LPER * H;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxIn = 1'b0;
  logic       rdEn = 1'b0;
  logic       ovfClr = 1'b0;
  logic [7:0] rdData;
  logic       fifoEmpty, fifoFull, carrierLock, carrierLoss, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bpsk_cmd_decoder #(
    .HALF_CLKS    (H),
    .BIT_CYCLES   (BITC),
    .LOCK_EDGES   (LEDG),
    .LOSS_PERIODS (LPER),
    .FIFO_DEPTH   (DEPTH)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .rxLine      (rxIn),
    .rdEn        (rdEn),
    .ovfClr      (ovfClr),
    .rdData      (rdData),
    .fifoEmpty   (fifoEmpty),
    .fifoFull    (fifoFull),
    .carrierLock (carrierLock),
    .carrierLoss (carrierLoss),
    .overflow    (overflow)
  );

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) fail(tag, what, act, exp);
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m1 = 0, m2 = 0, m3 = 0;
  int         since = 0;
  bit         mLocked = 0, mLoss = 0, mOvf = 0;
  int         qual = 0, slots = 0;
  bit         revAcc = 0;
  bit         pValid = 0, pBit = 0, pClr = 0;
  int         shiftVal = 0, nBits = 0;
  logic [7:0] mq[$];

  always @(posedge clk) begin
    if (rst) begin
      m1 = 0; m2 = 0; m3 = 0; since = 0;
      mLocked = 0; mLoss = 0; mOvf = 0; qual = 0; slots = 0; revAcc = 0;
      pValid = 0; pBit = 0; pClr = 0; shiftVal = 0; nBits = 0;
      mq.delete();
    end else begin
      bit fullPre, emptyPre, ovfSet, edgeNow, rv, nValid, nBit, nClr;
      fullPre  = (mq.size() == DEPTH);
      emptyPre = (mq.size() == 0);
      ovfSet   = 0;
      nValid = 0; nBit = 0; nClr = 0;
      // byte assembly and FIFO, acting on the previous cycle's decision
      if (rdEn && !emptyPre) void'(mq.pop_front());
      if (pClr) begin
        nBits = 0; shiftVal = 0;
      end else if (pValid) begin
        shiftVal = ((shiftVal << 1) | int'(pBit)) & 8'hFF;
        nBits++;
        if (nBits == 8) begin
          nBits = 0;
          if (fullPre) ovfSet = 1;
          else mq.push_back(shiftVal[7:0]);
        end
      end
      if (ovfSet) mOvf = 1;
      else if (ovfClr) mOvf = 0;
      // line timing
      edgeNow = (m2 != m3);
      m3 = m2; m2 = m1; m1 = rxIn;
      if (!mLocked) begin
        if (edgeNow) begin
          if (since >= H - H / 4 && since <= H + H / 4) begin
            qual++;
            if (qual == LEDG) begin
              mLocked = 1; mLoss = 0; qual = 0; slots = 0; revAcc = 0; nClr = 1;
            end
          end else qual = 0;
        end
      end else if (edgeNow) begin
        rv = (2 * since > 3 * H);
        slots += rv ? 2 : 1;
        if (slots >= 2 * BITC) begin
          nValid = 1; nBit = revAcc | rv; slots = 0; revAcc = 0;
        end else revAcc = revAcc | rv;
      end else if (since >= LOSS) begin
        mLocked = 0; mLoss = 1; nClr = 1;
      end
      since = edgeNow ? 1 : since + 1;
      pValid = nValid; pBit = nBit; pClr = nClr;
    end
  end

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (fifoEmpty !== (mq.size() == 0))     fail("R6", "fifoEmpty", int'(fifoEmpty), int'(mq.size() == 0));
      if (fifoFull !== (mq.size() == DEPTH))  fail("R6", "fifoFull", int'(fifoFull), int'(mq.size() == DEPTH));
      if (mq.size() != 0 && rdData !== mq[0]) fail("R5", "rdData", int'(rdData), int'(mq[0]));
      if (carrierLock !== mLocked)            fail("R2", "carrierLock", int'(carrierLock), int'(mLocked));
      if (carrierLoss !== mLoss)              fail("R4", "carrierLoss", int'(carrierLoss), int'(mLoss));
      if (overflow !== mOvf)                  fail("R7", "overflow", int'(overflow), int'(mOvf));
    end
  end

  // ---------------- stimulus ----------------
  logic curLvl = 1'b0;

  task automatic halfSlot(int len, bit toggle);
    if (toggle) curLvl = ~curLvl;
    rxIn = curLvl;
    repeat (len) @(negedge clk);
  endtask

  // One bit window; a 1 repeats the level in the middle half-slot.
  task automatic sendBit(bit b);
    for (int s = 0; s < 2 * BITC; s++) halfSlot(H, !(b && s == BITC));
  endtask

  task automatic sendByte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic readByte(logic [7:0] exp, string tag);
    chk(tag, "byte present", int'(fifoEmpty), 0);
    chk(tag, "byte value", int'(rdData), int'(exp));
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "empty in reset", int'(fifoEmpty), 1);
    chk("R1", "full in reset", int'(fifoFull), 0);
    chk("R1", "lock in reset", int'(carrierLock), 0);
    chk("R1", "loss in reset", int'(carrierLoss), 0);
    chk("R1", "overflow in reset", int'(overflow), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "lock after reset", int'(carrierLock), 0);
    chk("R1", "empty after reset", int'(fifoEmpty), 1);
    repeat (100) @(negedge clk);

    // Stream 1: interrupted qualification, then six bytes into a 4-deep FIFO.
    halfSlot(H, 1);
    repeat (9) halfSlot(H, 1);
    halfSlot(H / 2, 1);
    repeat (15) halfSlot(H, 1);
    chk("R2", "no lock after short half-cycle restart", int'(carrierLock), 0);
    halfSlot(H, 1);
    sendByte(8'hA5);
    chk("R2", "locked during data", int'(carrierLock), 1);
    sendByte(8'h3C);
    sendByte(8'h81);
    sendByte(8'hFF);
    sendByte(8'h00);
    sendByte(8'h5A);
    halfSlot(H, 1);
    repeat (LOSS + 10) @(negedge clk);
    chk("R4", "lock dropped on silence", int'(carrierLock), 0);
    chk("R4", "loss flagged", int'(carrierLoss), 1);
    chk("R6", "fifo full", int'(fifoFull), 1);
    chk("R7", "overflow set", int'(overflow), 1);
    readByte(8'hA5, "R3");
    readByte(8'h3C, "R3");
    readByte(8'h81, "R5");
    readByte(8'hFF, "R7");
    chk("R6", "empty after draining", int'(fifoEmpty), 1);
    // R8: reads on an empty FIFO
    rdEn = 1'b1;
    repeat (3) @(negedge clk);
    rdEn = 1'b0;
    chk("R8", "still empty", int'(fifoEmpty), 1);
    chk("R8", "not full", int'(fifoFull), 0);
    chk("R7", "overflow still sticky", int'(overflow), 1);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    chk("R7", "overflow cleared", int'(overflow), 0);

    // Stream 2: relock, three bytes and a partial one, then silence.
    repeat (16) halfSlot(H, 1);
    halfSlot(H, 1);
    sendByte(8'h96);
    chk("R4", "loss cleared on relock", int'(carrierLoss), 0);
    sendByte(8'h01);
    sendByte(8'h7E);
    sendBit(1'b1);
    sendBit(1'b0);
    sendBit(1'b1);
    halfSlot(H, 1);
    repeat (LOSS + 10) @(negedge clk);
    chk("R4", "loss after second stream", int'(carrierLoss), 1);
    readByte(8'h96, "R8");
    readByte(8'h01, "R3");
    readByte(8'h7E, "R5");
    chk("R4", "partial byte discarded", int'(fifoEmpty), 1);
    chk("R7", "no overflow in second stream", int'(overflow), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule